// File: doc/BRIEF.md
# Synthesizer Control Registers and Output Clock Dividers

This block holds the programming registers for three clock synthesizers in a graphics or video device: the memory clock, the pixel clock and the loop clock. Each synthesizer has three 8-bit values, a feedback divider, an input divider and a post-scaler with control bits. They are written through a single-cycle indexed write strobe and read back through a combinational indexed read port. The order of writes decides whether each synthesizer runs. Writing the input-divider value stops the synthesizer. Writing the post-scaler value starts it again. A lock bit in the post-scaler value keeps the synthesizer running regardless of write order.

The block also holds a divider control register that drives two gated, divided copies of the memory synthesizer output: a memory clock and a second derived clock. The analog synthesizer is modelled by the block clock `clk`. Each output divides it by an even ratio from 2 to 16, has a 50% duty cycle, stays low while disabled, and picks up a new ratio only at its next rising edge.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset the registers read back as follows: memory synthesizer N=0x05, M=0x09, P=0x01; pixel synthesizer N=0x06, M=0x05, P=0x02; loop synthesizer all 0x00; divider control 0x08; clock select 0x00. `synth_en` reads 3'b011 (bit 0 memory, bit 1 pixel, bit 2 loop).
- R2: Synthesizer s (0 memory, 1 pixel, 2 loop) has N at index 0x20+4s, M at 0x21+4s and P at 0x22+4s. Divider control is at 0x30 and clock select is at 0x31. A write stores `wr_data` at the index. A read of that index returns the stored value. Reads of any other index return 0x00, and writes to them change nothing that can be read back.
- R3: A write to a synthesizer's N register clears its `synth_en` bit in the cycle after the write, if bit 7 of its stored P register is 0.
- R4: A write to a synthesizer's P register sets its `synth_en` bit in the cycle after the write. While that P register's bit 7 is 1, a write to N leaves the bit set.
- R5: A write to a synthesizer's M register does not change its `synth_en` bit.
- R6: `pix_pin_en` equals bit 3 of the pixel synthesizer's P register.
- R7: `pix_src_sel` is 1 exactly when the clock select register holds 0x05.
- R8: Divider control bit 3 enables `mclk_out` and bits 2:0 hold its ratio code. Bit 7 enables `dclk_out` and bits 6:4 hold its ratio code. Code k gives a period of 2(k+1) `clk` cycles, with the output high for k+1 of them.
- R9: A disabled output stays low.
- R10: A new ratio code takes effect at the output's next rising edge. A high phase already in progress finishes with its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock and modelled memory synthesizer output |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_idx | input | 8 | Register index of the write |
| wr_data | input | 8 | Write data |
| rd_idx | input | 8 | Register index of the read |
| rd_data | output | 8 | Stored value at `rd_idx` |
| synth_en | output | 3 | Run enable per synthesizer (0 memory, 1 pixel, 2 loop) |
| pix_pin_en | output | 1 | Routes the pixel synthesizer output to its external pin |
| pix_src_sel | output | 1 | Selects the pixel synthesizer as pixel clock source |
| mclk_out | output | 1 | Gated, divided memory clock |
| dclk_out | output | 1 | Gated, divided second clock |

## Verification
The bench builds the block with its default parameters: three synthesizers, 3-bit ratio codes and the default register base indices. With these values every ratio code from 2 to 16 can be reached on both outputs. The bench runs N/M/P write sequences on the loop and memory synthesizers both with and without the lock bit set. It also changes a ratio in the middle of a long high phase, which shows that the old pulse finishes at full length before the new period starts.

// File: rtl/clkgen_pkg.sv
// Shared constants and reset values for the synthesizer control block.
// Assumes three synthesizers, each with three 8-bit registers.
package clkgen_pkg;
    localparam int NUM_SYN = 3;
    localparam int NUM_FLD = 3;

    typedef enum logic [1:0] {
        FLD_N = 2'd0,
        FLD_M = 2'd1,
        FLD_P = 2'd2
    } syn_fld_e;

    // Reset value of field f of synthesizer s.
    function automatic logic [7:0] syn_rst_val(int s, int f);
        logic [7:0] v;
        v = 8'h00;
        if (s == 0) begin
            if (f == 0) v = 8'h05;
            else if (f == 1) v = 8'h09;
            else v = 8'h01;
        end else if (s == 1) begin
            if (f == 0) v = 8'h06;
            else if (f == 1) v = 8'h05;
            else v = 8'h02;
        end
        return v;
    endfunction
endpackage

// File: rtl/clkgen_regs.sv
// Register file: synthesizer N/M/P values, divider control and clock select.
// Assumes one write per cycle and a combinational read port.
module clkgen_regs
    import clkgen_pkg::*;
#(
    parameter logic [7:0] SYN_BASE = 8'h20,
    parameter logic [7:0] DIV_IDX  = 8'h30,
    parameter logic [7:0] SEL_IDX  = 8'h31,
    parameter logic [7:0] DIV_RST  = 8'h08
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [NUM_SYN-1:0] n_wr,
    output logic [NUM_SYN-1:0] m_wr,
    output logic [NUM_SYN-1:0] p_wr,
    output logic [NUM_SYN-1:0] p_lock,
    output logic               pix_pout,
    output logic [7:0]         div_q,
    output logic [7:0]         sel_q
);
    logic [7:0] syn_q [NUM_SYN][NUM_FLD];

    for (genvar s = 0; s < NUM_SYN; s++) begin : g_syn
        for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
            localparam logic [7:0] IDX = 8'(int'(SYN_BASE) + 4 * s + f);
            // Store one synthesizer field on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) syn_q[s][f] <= syn_rst_val(s, f);
                else if (wr_en && wr_idx == IDX) syn_q[s][f] <= wr_data;
            end
        end
        assign n_wr[s]   = wr_en && (wr_idx == 8'(int'(SYN_BASE) + 4 * s + int'(FLD_N)));
        assign m_wr[s]   = wr_en && (wr_idx == 8'(int'(SYN_BASE) + 4 * s + int'(FLD_M)));
        assign p_wr[s]   = wr_en && (wr_idx == 8'(int'(SYN_BASE) + 4 * s + int'(FLD_P)));
        assign p_lock[s] = syn_q[s][FLD_P][7];
    end

    assign pix_pout = syn_q[1][FLD_P][3];

    // Divider control and clock select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_RST;
            sel_q <= 8'h00;
        end else if (wr_en) begin
            if (wr_idx == DIV_IDX) div_q <= wr_data;
            if (wr_idx == SEL_IDX) sel_q <= wr_data;
        end
    end

    // Read mux; unmapped indices return zero.
    always_comb begin
        rd_data = 8'h00;
        if (rd_idx == DIV_IDX) rd_data = div_q;
        if (rd_idx == SEL_IDX) rd_data = sel_q;
        for (int s = 0; s < NUM_SYN; s++)
            for (int f = 0; f < NUM_FLD; f++)
                if (rd_idx == 8'(int'(SYN_BASE) + 4 * s + f)) rd_data = syn_q[s][f];
    end
endmodule

// File: rtl/clkgen_syn_en.sv
// Run enable for one synthesizer, driven by the order of writes.
// Assumes N and P write strobes never coincide (single index per cycle).
module clkgen_syn_en #(
    parameter bit RST_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic n_wr,
    input  logic p_wr,
    input  logic p_lock,
    output logic en
);
    // P write starts the synthesizer, N write stops it unless locked.
    always_ff @(posedge clk) begin
        if (!rst_n) en <= RST_EN;
        else if (p_wr) en <= 1'b1;
        else if (n_wr && !p_lock) en <= 1'b0;
    end

    assert_n_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (n_wr && !p_lock) |=> !en);
    assert_p_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        p_wr |=> en);
    assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (n_wr && p_lock && en) |=> en);
endmodule

// File: rtl/clkgen_div.sv
// Gated even-ratio clock divider with 50% duty cycle.
// Ratio code k gives 2(k+1) input cycles per period; a code change is taken
// up only at the next rising edge of the output; disabled output is low.
module clkgen_div #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              out
);
    logic [CODE_W-1:0] act_code;
    logic [CODE_W-1:0] cnt;

    // Phase counter, output toggle and ratio pickup at the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out      <= 1'b0;
            cnt      <= '0;
            act_code <= '0;
        end else if (!en) begin
            out      <= 1'b0;
            cnt      <= '0;
            act_code <= code;
        end else if (cnt == act_code) begin
            cnt <= '0;
            out <= !out;
            if (!out) act_code <= code;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out);
    assert_ratio_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out && $past(out)) |-> $stable(act_code));
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_code);
endmodule

// File: rtl/clkgen_ctrl.sv
// Top: synthesizer control registers, write-order run enables and two
// gated output dividers. The memory synthesizer output is modelled by clk.
module clkgen_ctrl
    import clkgen_pkg::*;
#(
    parameter logic [7:0] SYN_BASE = 8'h20,
    parameter logic [7:0] DIV_IDX  = 8'h30,
    parameter logic [7:0] SEL_IDX  = 8'h31,
    parameter logic [7:0] PIX_SRC  = 8'h05,
    parameter int         CODE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [NUM_SYN-1:0] synth_en,
    output logic               pix_pin_en,
    output logic               pix_src_sel,
    output logic               mclk_out,
    output logic               dclk_out
);
    localparam int FIELD_W = 4;
    localparam int NUM_OUT = 2;

    logic [NUM_SYN-1:0] n_wr, m_wr, p_wr, p_lock;
    logic [7:0]         div_q, sel_q;
    logic               pix_pout;
    logic [NUM_OUT-1:0] div_out;

    clkgen_regs #(
        .SYN_BASE(SYN_BASE), .DIV_IDX(DIV_IDX), .SEL_IDX(SEL_IDX), .DIV_RST(8'h08)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .n_wr(n_wr), .m_wr(m_wr), .p_wr(p_wr),
        .p_lock(p_lock), .pix_pout(pix_pout), .div_q(div_q), .sel_q(sel_q)
    );

    for (genvar s = 0; s < NUM_SYN; s++) begin : g_en
        clkgen_syn_en #(.RST_EN(s != 2)) u_en (
            .clk(clk), .rst_n(rst_n), .n_wr(n_wr[s]), .p_wr(p_wr[s]),
            .p_lock(p_lock[s]), .en(synth_en[s])
        );
        assert_m_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
            m_wr[s] |=> $stable(synth_en[s]));
    end

    // Output 0 is the memory clock (low nibble), output 1 the second clock.
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
        clkgen_div #(.CODE_W(CODE_W)) u_div (
            .clk(clk), .rst_n(rst_n), .en(div_q[g*FIELD_W + FIELD_W - 1]),
            .code(div_q[g*FIELD_W +: CODE_W]), .out(div_out[g])
        );
    end

    assign mclk_out    = div_out[0];
    assign dclk_out    = div_out[1];
    assign pix_pin_en  = pix_pout;
    assign pix_src_sel = (sel_q == PIX_SRC);
endmodule

// File: tb/clkgen_ctrl_test.sv
module clkgen_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_idx = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_idx = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] synth_en;
    logic       pix_pin_en, pix_src_sel, mclk_out, dclk_out;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    clkgen_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .synth_en(synth_en),
        .pix_pin_en(pix_pin_en), .pix_src_sel(pix_src_sel),
        .mclk_out(mclk_out), .dclk_out(dclk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] idx, input logic [7:0] exp);
        rd_idx = idx;
        #1;
        check(req, rd_data, exp);
    endtask

    function automatic logic pick(input bit sel);
        return sel ? dclk_out : mclk_out;
    endfunction

    // Waits for the next rising edge (seen at negedge samples).
    task automatic wait_rise(input bit sel);
        logic prev;
        prev = pick(sel);
        forever begin
            @(negedge clk);
            if (!prev && pick(sel)) break;
            prev = pick(sel);
        end
    endtask

    // Measures one period and its high time from a rising edge.
    task automatic measure(input string req, input bit sel, input int per, input int hi);
        int p = 1;
        int h = 1;
        logic prev;
        wait_rise(sel);
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!prev && pick(sel)) break;
            prev = pick(sel);
            p++;
            if (pick(sel)) h++;
        end
        check({req, " period"}, p, per);
        check({req, " high"}, h, hi);
    endtask

    task automatic t_reset();
        check("R1 synth_en", synth_en, 3'b011);
        rd_check("R1 mem N", 8'h20, 8'h05);
        rd_check("R1 mem M", 8'h21, 8'h09);
        rd_check("R1 mem P", 8'h22, 8'h01);
        rd_check("R1 pix N", 8'h24, 8'h06);
        rd_check("R1 pix M", 8'h25, 8'h05);
        rd_check("R1 pix P", 8'h26, 8'h02);
        rd_check("R1 loop N", 8'h28, 8'h00);
        rd_check("R1 loop P", 8'h2A, 8'h00);
        rd_check("R1 div ctrl", 8'h30, 8'h08);
        rd_check("R1 clk sel", 8'h31, 8'h00);
        check("R6 pin off at reset", pix_pin_en, 0);
        check("R7 src off at reset", pix_src_sel, 0);
    endtask

    task automatic t_regmap();
        wr(8'h29, 8'h3C);
        rd_check("R2 loop M", 8'h29, 8'h3C);
        wr(8'h7F, 8'hAA);
        rd_check("R2 unmapped", 8'h7F, 8'h00);
        rd_check("R2 unmapped 2B", 8'h2B, 8'h00);
        rd_check("R2 div untouched", 8'h30, 8'h08);
    endtask

    task automatic t_order();
        wr(8'h2A, 8'h03);
        check("R4 loop P starts", synth_en[2], 1);
        wr(8'h28, 8'h07);
        check("R3 loop N stops", synth_en[2], 0);
        wr(8'h29, 8'h11);
        check("R5 M keeps off", synth_en[2], 0);
        wr(8'h2A, 8'h01);
        wr(8'h29, 8'h12);
        check("R5 M keeps on", synth_en[2], 1);
        wr(8'h2A, 8'h81);
        wr(8'h28, 8'h04);
        check("R4 locked N keeps on", synth_en[2], 1);
        wr(8'h20, 8'h05);
        check("R3 mem N stops", synth_en[0], 0);
        check("R3 pix untouched", synth_en[1], 1);
        wr(8'h22, 8'h01);
        check("R4 mem P starts", synth_en[0], 1);
    endtask

    task automatic t_pix();
        wr(8'h26, 8'h0A);
        check("R6 pin on", pix_pin_en, 1);
        wr(8'h26, 8'h02);
        check("R6 pin off", pix_pin_en, 0);
        wr(8'h31, 8'h05);
        check("R7 src on", pix_src_sel, 1);
        wr(8'h31, 8'h04);
        check("R7 src off", pix_src_sel, 0);
    endtask

    task automatic t_div();
        measure("R8 mclk default", 1'b0, 2, 1);
        wr(8'h30, 8'hAB);
        measure("R8 mclk code3", 1'b0, 8, 4);
        measure("R8 dclk code2", 1'b1, 6, 3);
        wr(8'h30, 8'h0F);
        measure("R8 mclk code7", 1'b0, 16, 8);
    endtask

    task automatic t_off();
        int hi = 0;
        wr(8'h30, 8'h03);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mclk_out || dclk_out) hi++;
        end
        check("R9 disabled low", hi, 0);
    endtask

    task automatic t_change();
        int h = 1;
        wr(8'h30, 8'hF0);
        wait_rise(1'b1);
        wr_en = 1'b1; wr_idx = 8'h30; wr_data = 8'h90;
        forever begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!dclk_out) break;
            h++;
        end
        check("R10 old high kept", h, 8);
        measure("R10 new ratio", 1'b1, 4, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_order();
        t_pix();
        t_div();
        t_off();
        t_change();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule